// File: doc/BRIEF.md
# BCD Watchdog Countdown Timer

This block is a watchdog timer that software programs through a small byte-wide register port. The timeout sits in two BCD bytes: one holds whole seconds (00 to 99) and one holds hundredths of a second (00 to 99), so the longest timeout is 99.99 s. An external strobe arrives at 100 Hz. While the watchdog is enabled, each strobe takes one hundredth off a running BCD count, with a digit-by-digit borrow.

When the count steps from 00.01 to 00.00, the timer has expired. It then sets a status flag and drives one of two outputs. A steering bit in the control register chooses which one: a reset pulse of fixed width, or a level interrupt. The interrupt stays high until software reads the status register. A write to either count register restarts the countdown from the values held in both registers. Software that services the watchdog therefore rewrites a count register before the count runs out.

Loading zero into both count registers leaves the timer idle, because a count of zero never expires. Building the 100 Hz strobe from a crystal is done outside this block.

Top module: `bcd_watchdog`

## Requirements
- R1: The register port decodes four offsets: 0xC holds the hundredths byte and 0xD holds the seconds byte (each byte is two BCD digits, tens in bits 7:4). In the control byte at 0xF, bit 1 enables the watchdog and bit 0 is the steering bit, and the other bits read 0. Read data appears on `bus_rdata` the cycle after `bus_rd`, and unmapped offsets read 0.
- R2: While enabled, each one-cycle `tick_i` strobe takes one hundredth off the running count. A load of N hundredths expires on exactly the N-th strobe.
- R3: The decrement borrows in BCD: hundredths 00 becomes 99 and one is taken from the seconds. A load of 01.00 expires on the 100th strobe and a load of 99.99 expires on the 9999th strobe.
- R4: With the steering bit 0, expiry raises `wd_irq` on the clock edge that takes the expiring strobe. `wd_irq` stays high until a read of offset 0xE, and `wd_rst` stays low.
- R5: Offset 0xE reads 0x02 (bit 1 set) once the timer has expired. That read clears both the flag and `wd_irq`, so a second read returns 0x00.
- R6: With the steering bit 1, expiry drives `wd_rst` high for exactly 4 clock cycles and leaves `wd_irq` low. The status flag is still set.
- R7: With zero in both count registers, strobes never cause an expiry.
- R8: A write to either count register reloads the whole running count from both registers. A write in the same cycle as a strobe takes priority over the strobe.
- R9: While the enable bit is 0, strobes are ignored and the running count is held. Counting resumes from the held value once the bit is set again.
- R10: After expiry the count stays at 00.00. Further strobes cause no new expiry until the next load.
- R11: After reset, all registers read 0 and both `wd_irq` and `wd_rst` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle 100 Hz strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| wd_irq | output | 1 | Expiry interrupt, held until the status register is read |
| wd_rst | output | 1 | Expiry reset pulse |

## Verification
The assertions take three things for granted about the inputs:
- `tick_i` is a strobe.
- Each register access lasts one cycle.
- The count registers hold valid BCD digits (0 to 9), so the borrow chain only ever sees legal digits.

The bench keeps within these limits. It changes inputs only on falling edges and raises each strobe and each access for a single cycle. It writes only legal BCD bytes. It never re-arms an expiry while a reset pulse is still running, which the width check relies on.

// File: rtl/bcdwd_pkg.sv
package bcdwd_pkg;

    // Register offsets: software decodes these, so they stay fixed.
    localparam logic [3:0] OFS_HUND = 4'hC;
    localparam logic [3:0] OFS_SECS = 4'hD;
    localparam logic [3:0] OFS_STAT = 4'hE;
    localparam logic [3:0] OFS_CTRL = 4'hF;

    // Bit positions inside the control and status bytes.
    localparam int CTRL_EN_BIT    = 1;
    localparam int CTRL_STEER_BIT = 0;
    localparam int STAT_FLAG_BIT  = 1;

    localparam int BCD_DIGIT_W = 4;

    typedef logic [BCD_DIGIT_W-1:0] bcd_digit_t;

endpackage

// File: rtl/bcdwd_regs.sv
module bcdwd_regs
    import bcdwd_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                flag_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                en_o,
    output logic                steer_o,
    output logic                load_o,
    output logic [2*DATA_W-1:0] load_val_o,
    output logic                stat_rd_o
);

    typedef struct packed {
        logic [DATA_W-1:0] hund;
        logic [DATA_W-1:0] secs;
        logic              en;
        logic              steer;
        logic [DATA_W-1:0] rdata;
    } regs_st_t;

    regs_st_t q, d;

    logic hit_hund, hit_secs, hit_ctrl;

    always_comb begin
        d        = q;
        hit_hund = wr_en && (addr == ADDR_W'(OFS_HUND));
        hit_secs = wr_en && (addr == ADDR_W'(OFS_SECS));
        hit_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));

        if (hit_hund) d.hund = wdata;
        if (hit_secs) d.secs = wdata;
        if (hit_ctrl) begin
            d.en    = wdata[CTRL_EN_BIT];
            d.steer = wdata[CTRL_STEER_BIT];
        end

        if (rd_en) begin
            d.rdata = '0;
            if (addr == ADDR_W'(OFS_HUND)) begin
                d.rdata = q.hund;
            end else if (addr == ADDR_W'(OFS_SECS)) begin
                d.rdata = q.secs;
            end else if (addr == ADDR_W'(OFS_STAT)) begin
                d.rdata[STAT_FLAG_BIT] = flag_i;
            end else if (addr == ADDR_W'(OFS_CTRL)) begin
                d.rdata[CTRL_EN_BIT]    = q.en;
                d.rdata[CTRL_STEER_BIT] = q.steer;
            end
        end

        // The reload takes the freshly written byte together with the other held byte.
        load_o     = hit_hund || hit_secs;
        load_val_o = {d.secs, d.hund};
        stat_rd_o  = rd_en && (addr == ADDR_W'(OFS_STAT));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata_o = q.rdata;
    assign en_o    = q.en;
    assign steer_o = q.steer;

    // R1: a control write lands in the enable bit on the next cycle
    a_r1_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_CTRL)) |=> (en_o == $past(wdata[CTRL_EN_BIT])));

endmodule

// File: rtl/bcdwd_count.sv
module bcdwd_count
    import bcdwd_pkg::*;
#(
    parameter int NDIG = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick_i,
    input  logic                        en_i,
    input  logic                        load_i,
    input  logic [NDIG*BCD_DIGIT_W-1:0] load_val_i,
    output logic                        expire_o
);

    localparam int CNT_W = NDIG * BCD_DIGIT_W;
    localparam logic [CNT_W-1:0] ONE_LSB = CNT_W'(1);

    typedef struct packed {
        logic [NDIG-1:0][BCD_DIGIT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t q, d;

    logic [NDIG-1:0]                  lower_zero;
    logic [NDIG-1:0][BCD_DIGIT_W-1:0] dec;
    logic                             is_zero, is_one, step;

    // A digit borrows only when every digit below it is zero.
    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        if (g == 0) begin : g_lsd
            assign lower_zero[g] = 1'b1;
        end else begin : g_upper
            assign lower_zero[g] = (q.cnt[g-1:0] == '0);
        end
        assign dec[g] = !lower_zero[g]        ? q.cnt[g] :
                        (q.cnt[g] == 4'd0)    ? bcd_digit_t'(9) :
                                                q.cnt[g] - bcd_digit_t'(1);
    end

    always_comb begin
        d        = q;
        is_zero  = (q.cnt == '0);
        is_one   = (q.cnt == ONE_LSB);
        step     = tick_i && en_i && !is_zero;
        expire_o = step && !load_i && is_one;
        if (load_i)    d.cnt = load_val_i;
        else if (step) d.cnt = dec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R10: a count of zero stays at zero until a reload
    a_r10_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == '0 && !load_i) |=> (q.cnt == '0));

    // R9: with the enable bit off and no reload, the count is held
    a_r9_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !load_i) |=> $stable(q.cnt));

    // R2: the count moves only on a strobe or a reload
    a_r2_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(q.cnt));

    // R8: a reload wins over a strobe in the same cycle
    a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (q.cnt == $past(load_val_i)));

endmodule

// File: rtl/bcdwd_expiry.sv
module bcdwd_expiry #(
    parameter int PULSE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic steer_i,
    input  logic stat_rd_i,
    output logic flag_o,
    output logic irq_o,
    output logic rst_o
);

    localparam int PW = $clog2(PULSE + 1);

    typedef struct packed {
        logic          flag;
        logic          irq;
        logic [PW-1:0] pcnt;
    } exp_st_t;

    exp_st_t q, d;

    always_comb begin
        d = q;
        // The status read clears first, so an expiry in the same cycle still sets.
        if (stat_rd_i) begin
            d.flag = 1'b0;
            d.irq  = 1'b0;
        end
        if (q.pcnt != '0) d.pcnt = q.pcnt - PW'(1);
        if (expire_i) begin
            d.flag = 1'b1;
            if (steer_i) d.pcnt = PW'(PULSE);
            else         d.irq  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flag_o = q.flag;
    assign irq_o  = q.irq;
    assign rst_o  = (q.pcnt != '0);

    // Length of the current reset pulse, for the width check.
    logic [PW:0] hi_run;
    always_ff @(posedge clk) begin
        if (!rst_n || expire_i || !rst_o) hi_run <= '0;
        else if (hi_run != '1)            hi_run <= hi_run + 1'b1;
    end

    // R6: the reset pulse never runs past its width
    a_r6_rst_width: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_run <= (PW + 1)'(PULSE)));

    // R6: the interrupt rises only on an unsteered expiry
    a_r6_irq_unsteered: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(expire_i && !steer_i));

    // R4: the interrupt holds until the status read
    a_r4_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !stat_rd_i) |=> irq_o);

    // R5: every expiry leaves the flag set
    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> flag_o);

endmodule

// File: rtl/bcd_watchdog.sv
module bcd_watchdog
    import bcdwd_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int RST_PULSE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_irq,
    output logic              wd_rst
);

    localparam int NDIG = 2 * DATA_W / BCD_DIGIT_W;

    logic                en, steer, load, stat_rd, expire, flag;
    logic [2*DATA_W-1:0] load_val;

    bcdwd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .rd_en      (bus_rd),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .flag_i     (flag),
        .rdata_o    (bus_rdata),
        .en_o       (en),
        .steer_o    (steer),
        .load_o     (load),
        .load_val_o (load_val),
        .stat_rd_o  (stat_rd)
    );

    bcdwd_count #(.NDIG(NDIG)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .en_i       (en),
        .load_i     (load),
        .load_val_i (load_val),
        .expire_o   (expire)
    );

    bcdwd_expiry #(.PULSE(RST_PULSE_W)) u_expiry (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire_i  (expire),
        .steer_i   (steer),
        .stat_rd_i (stat_rd),
        .flag_o    (flag),
        .irq_o     (wd_irq),
        .rst_o     (wd_rst)
    );

endmodule

// File: tb/tb_bcd_watchdog.sv
module tb_bcd_watchdog;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       wd_irq, wd_rst;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bcd_watchdog dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wd_irq(wd_irq), .wd_rst(wd_rst)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
        end
    endtask

    task automatic clear_flag();
        logic [7:0] v;
        rd(4'hE, v);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R11 irq after reset", wd_irq, 0);
        check("R11 rst after reset", wd_rst, 0);
        rd(4'hC, v); check("R11 hund after reset", v, 8'h00);
        rd(4'hD, v); check("R11 secs after reset", v, 8'h00);
        rd(4'hF, v); check("R11 ctrl after reset", v, 8'h00);
        rd(4'hE, v); check("R11 stat after reset", v, 8'h00);
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        wr(4'hC, 8'h47);
        wr(4'hD, 8'h83);
        wr(4'hF, 8'hFF);
        rd(4'hC, v); check("R1 hund readback", v, 8'h47);
        rd(4'hD, v); check("R1 secs readback", v, 8'h83);
        rd(4'hF, v); check("R1 ctrl readback", v, 8'h03);
        rd(4'h3, v); check("R1 unmapped offset", v, 8'h00);
        wr(4'hF, 8'h00);
        wr(4'hC, 8'h00);
        wr(4'hD, 8'h00);
    endtask

    task automatic t_irq_expiry();
        logic [7:0] v;
        wr(4'hF, 8'h02);
        wr(4'hD, 8'h00);
        wr(4'hC, 8'h03);
        tick(2);
        check("R2 no irq before third strobe", wd_irq, 0);
        tick(1);
        check("R2 R4 irq on third strobe", wd_irq, 1);
        check("R4 no reset when unsteered", wd_rst, 0);
        repeat (5) @(negedge clk);
        check("R4 irq held", wd_irq, 1);
        rd(4'hE, v);
        check("R5 status flag", v, 8'h02);
        check("R5 irq cleared by read", wd_irq, 0);
        rd(4'hE, v);
        check("R5 second status read", v, 8'h00);
    endtask

    task automatic t_stop_at_zero();
        logic [7:0] v;
        tick(20);
        check("R10 no refire after expiry", wd_irq, 0);
        rd(4'hE, v);
        check("R10 flag stays clear", v, 8'h00);
    endtask

    task automatic t_reset_steer();
        logic [7:0] v;
        int width = 0;
        wr(4'hF, 8'h03);
        wr(4'hC, 8'h02);
        tick(2);
        while (wd_rst && width < 20) begin
            width++;
            check("R6 irq stays low during pulse", wd_irq, 0);
            @(negedge clk);
        end
        check("R6 reset pulse width", width, 4);
        rd(4'hE, v);
        check("R6 flag set on steered expiry", v, 8'h02);
    endtask

    task automatic t_borrow();
        wr(4'hF, 8'h02);
        wr(4'hC, 8'h00);
        wr(4'hD, 8'h01);
        tick(99);
        check("R3 01.00 not yet expired", wd_irq, 0);
        tick(1);
        check("R3 01.00 expires on 100th", wd_irq, 1);
        clear_flag();
    endtask

    task automatic t_max();
        wr(4'hC, 8'h99);
        wr(4'hD, 8'h99);
        tick(9998);
        check("R3 99.99 not yet expired", wd_irq, 0);
        tick(1);
        check("R3 99.99 expires on 9999th", wd_irq, 1);
        clear_flag();
    endtask

    task automatic t_zero_load();
        logic [7:0] v;
        wr(4'hC, 8'h00);
        wr(4'hD, 8'h00);
        tick(50);
        check("R7 zero load no irq", wd_irq, 0);
        rd(4'hE, v);
        check("R7 zero load no flag", v, 8'h00);
    endtask

    task automatic t_reload();
        wr(4'hC, 8'h10);
        tick(8);
        wr(4'hD, 8'h00);
        tick(9);
        check("R8 seconds write reloaded count", wd_irq, 0);
        tick(1);
        check("R8 expiry after reload", wd_irq, 1);
        clear_flag();
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'hC; bus_wdata = 8'h03; tick_i = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_i = 1'b0;
        tick(2);
        check("R8 load beats same-cycle strobe", wd_irq, 0);
        tick(1);
        check("R8 full count after collision", wd_irq, 1);
        clear_flag();
    endtask

    task automatic t_disabled();
        wr(4'hF, 8'h00);
        wr(4'hC, 8'h05);
        tick(10);
        check("R9 strobes ignored when disabled", wd_irq, 0);
        wr(4'hF, 8'h02);
        tick(4);
        check("R9 held count not yet expired", wd_irq, 0);
        tick(1);
        check("R9 resumes from held count", wd_irq, 1);
        clear_flag();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_irq_expiry();
        t_stop_at_zero();
        t_reset_steer();
        t_borrow();
        t_max();
        t_zero_load();
        t_reload();
        t_disabled();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired before the bench finished");
        finish_run();
    end

endmodule